// File: doc/BRIEF.md
# Overflow Address-Data Table with Commit Drain

The block is a small on-chip store for transactional cache lines that no longer fit in a processor's local buffers. Each slot keeps a valid flag, a mark that says whether the owner wrote or only read the block, the block address, the buffered data and the identifier of the owning transaction. A live count of occupied slots is always visible. In the common case this count is zero, and callers can skip the table entirely. Several slots may hold the same address when more than one transaction has read it.

Lookups are combinational and see every visible slot. A commit command is the logical commit. After it, the block drains the owner's slots one at a time, lowest slot index first. A written slot is offered on a memory write port, and the slot is freed only when that write is accepted. A read-only slot is freed without a write. Because data leaves the table only after memory has taken it, a lookup during the drain never needs memory's possibly stale copy. An abort command hides the owner's slots from lookups at once and then frees them one per cycle without writing memory. Every freed slot produces a removal event for an external conflict filter, one cycle after the slot is freed.

Back-pressure: the insert stream (`ins_valid`/`ins_ready`) transfers when both are high, and `ins_ready` is low while a drain or abort walk is running. The memory write stream (`mw_valid`/`mw_ready`) holds its address and data steady until `mw_ready` is seen.

Top module: `ovf_table`

## Requirements
- R1: After reset the table is empty: `ovf_count` is 0, `drain_busy`, `commit_live`, `mw_valid` and `rm_valid` are low, and `ins_ready` is high.
- R2: An insert transfer stores address, data, write mark and owner in the lowest-index free slot, and the stored data is returned by a lookup of that address from the next cycle.
- R3: An insert transfer when all slots are occupied raises `ins_err` in that same cycle and changes no slot and no count.
- R4: `lk_hit` is high when any visible slot holds `lk_addr`. `lk_written` is high when a visible written slot holds it, and `lk_data` is the data of the lowest-index such slot, or 0 when there is none.
- R5: A commit command accepted in cycle t makes `drain_busy` and `commit_live` high from t+1 until the walk finds no slot of that owner. Each walk cycle takes the owner's lowest-index slot. A written slot is presented on the memory port and freed in the cycle `mw_valid && mw_ready`. A read-only slot is freed in its own cycle with no write.
- R6: While `mw_valid` is high and `mw_ready` low, `mw_valid`, `mw_addr` and `mw_data` stay unchanged in the next cycle.
- R7: A slot being drained stays visible to lookups, with its data, up to and including the cycle in which its memory write is accepted.
- R8: An abort command accepted in cycle t hides the owner's slots from lookups from t+1, frees them one per cycle in lowest-index order, and never raises `mw_valid` or `commit_live`.
- R9: Each slot freed in cycle t produces `rm_valid` in cycle t+1, with `rm_addr` equal to that slot's address.
- R10: While `drain_busy` is high, `ins_ready` is low, and commands are ignored.
- R11: An insert accepted in the same cycle as a command is stored before the walk begins, so an insert for the committing owner is drained by that commit.
- R12: A commit or abort for an owner with no slots keeps `drain_busy` high for exactly one cycle.
- R13: `ovf_count` always equals the number of occupied slots and never exceeds the slot count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_ready | output | 1 | Insert accepted when high (low during a walk) |
| ins_addr | input | AW | Block address of the evicted line |
| ins_data | input | DW | Buffered data |
| ins_write | input | 1 | 1 = line was written, 0 = only read |
| ins_owner | input | OW | Owning transaction identifier |
| ins_err | output | 1 | Insert transfer refused because the table is full |
| lk_addr | input | AW | Lookup address |
| lk_hit | output | 1 | Some visible slot holds the address |
| lk_written | output | 1 | A visible written slot holds the address |
| lk_data | output | DW | Data of the lowest-index visible written match |
| cmd_valid | input | 1 | Command strobe |
| cmd_commit | input | 1 | 1 = commit, 0 = abort |
| cmd_owner | input | OW | Target transaction |
| drain_busy | output | 1 | Commit drain or abort walk in progress |
| commit_live | output | 1 | A committing transaction is draining |
| mw_valid | output | 1 | Memory write offered |
| mw_ready | input | 1 | Memory accepts the write |
| mw_addr | output | AW | Memory write address |
| mw_data | output | DW | Memory write data |
| rm_valid | output | 1 | Removal event toward the conflict filter |
| rm_addr | output | AW | Address of the removed slot |
| ovf_count | output | CW | Number of occupied slots |

## Verification
Two collisions are provoked on purpose. In the first, an insert for the committing owner arrives in the same cycle as its commit command; it is judged by whether that address later appears on the memory port ahead of the owner's older slots. In the second, lookups run while a drain is stalled by a toggling `mw_ready`, and each cycle's `lk_data` and `lk_written` are compared against a behavioural model that frees a slot only at the accepted write. A command and an insert issued during a busy walk are checked to leave the count and the drain untouched.

// File: rtl/ovf_table_pkg.sv
package ovf_table_pkg;
  typedef enum logic {
    WALK_ABORT  = 1'b0,
    WALK_COMMIT = 1'b1
  } walk_mode_e;
endpackage

// File: rtl/ovf_prio.sv
module ovf_prio #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ovf_lookup.sv
module ovf_lookup #(
  parameter int N  = 8,
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic [N-1:0]  vis,
  input  logic [N-1:0]  wmark,
  input  logic [AW-1:0] ent_addr [N],
  input  logic [DW-1:0] ent_data [N],
  input  logic [AW-1:0] lk_addr,
  output logic          hit,
  output logic          written,
  output logic [DW-1:0] data
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  match;
  logic [N-1:0]  wmatch;
  logic [IW-1:0] widx;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign match[g]  = vis[g] && (ent_addr[g] == lk_addr);
      assign wmatch[g] = match[g] && wmark[g];
    end
  endgenerate

  ovf_prio #(.N(N)) u_wpick (.req(wmatch), .found(written), .idx(widx));

  assign hit  = |match;
  assign data = written ? ent_data[widx] : '0;
endmodule

// File: rtl/ovf_drain.sv
module ovf_drain
  import ovf_table_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int OW = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_commit,
  input  logic [OW-1:0] cmd_owner,
  input  logic [N-1:0]  ent_valid,
  input  logic [N-1:0]  ent_wmark,
  input  logic [OW-1:0] ent_owner [N],
  input  logic [AW-1:0] ent_addr [N],
  input  logic [DW-1:0] ent_data [N],
  input  logic          mw_ready,
  output logic          busy,
  output walk_mode_e    mode,
  output logic [OW-1:0] cur_owner,
  output logic          free_en,
  output logic [IW-1:0] free_idx,
  output logic          mw_valid,
  output logic [AW-1:0] mw_addr,
  output logic [DW-1:0] mw_data,
  output logic          rm_valid,
  output logic [AW-1:0] rm_addr
);
  logic [N-1:0]  own_mask;
  logic          sel_found;
  logic [IW-1:0] sel_idx;
  logic          needs_write;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_own
      assign own_mask[g] = ent_valid[g] && (ent_owner[g] == cur_owner);
    end
  endgenerate

  ovf_prio #(.N(N)) u_sel (.req(own_mask), .found(sel_found), .idx(sel_idx));

  assign needs_write = (mode == WALK_COMMIT) && ent_wmark[sel_idx];
  assign mw_valid    = busy && sel_found && needs_write;
  assign mw_addr     = ent_addr[sel_idx];
  assign mw_data     = ent_data[sel_idx];
  assign free_en     = busy && sel_found && (!needs_write || mw_ready);
  assign free_idx    = sel_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      mode      <= WALK_ABORT;
      cur_owner <= '0;
      rm_valid  <= 1'b0;
      rm_addr   <= '0;
    end else begin
      rm_valid <= free_en;
      if (free_en) rm_addr <= ent_addr[sel_idx];
      if (!busy) begin
        if (cmd_valid) begin
          busy      <= 1'b1;
          mode      <= cmd_commit ? WALK_COMMIT : WALK_ABORT;
          cur_owner <= cmd_owner;
        end
      end else if (!sel_found) begin
        busy <= 1'b0;
      end
    end
  end

  p_mw_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)));

  p_rm_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    free_en |=> rm_valid);

  p_abort_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode == WALK_ABORT) |-> !mw_valid);
endmodule

// File: rtl/ovf_table.sv
module ovf_table
  import ovf_table_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int OW = 2,
  localparam int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  output logic          ins_ready,
  input  logic [AW-1:0] ins_addr,
  input  logic [DW-1:0] ins_data,
  input  logic          ins_write,
  input  logic [OW-1:0] ins_owner,
  output logic          ins_err,
  input  logic [AW-1:0] lk_addr,
  output logic          lk_hit,
  output logic          lk_written,
  output logic [DW-1:0] lk_data,
  input  logic          cmd_valid,
  input  logic          cmd_commit,
  input  logic [OW-1:0] cmd_owner,
  output logic          drain_busy,
  output logic          commit_live,
  output logic          mw_valid,
  input  logic          mw_ready,
  output logic [AW-1:0] mw_addr,
  output logic [DW-1:0] mw_data,
  output logic          rm_valid,
  output logic [AW-1:0] rm_addr,
  output logic [CW-1:0] ovf_count
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  valid_q;
  logic [N-1:0]  wmark_q;
  logic [AW-1:0] addr_q  [N];
  logic [DW-1:0] data_q  [N];
  logic [OW-1:0] owner_q [N];
  logic [CW-1:0] count_q;

  logic          busy;
  walk_mode_e    mode;
  logic [OW-1:0] cur_owner;
  logic          free_en;
  logic [IW-1:0] free_idx;
  logic          slot_found;
  logic [IW-1:0] slot_idx;
  logic          ins_ok;
  logic [N-1:0]  vis;

  ovf_prio #(.N(N)) u_slot (.req(~valid_q), .found(slot_found), .idx(slot_idx));

  assign ins_ready = !busy;
  assign ins_ok    = ins_valid && ins_ready && slot_found;
  assign ins_err   = ins_valid && ins_ready && !slot_found;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_vis
      assign vis[g] = valid_q[g] &&
                      !(busy && mode == WALK_ABORT && owner_q[g] == cur_owner);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      wmark_q <= '0;
      count_q <= '0;
      for (int i = 0; i < N; i++) begin
        addr_q[i]  <= '0;
        data_q[i]  <= '0;
        owner_q[i] <= '0;
      end
    end else begin
      if (ins_ok) begin
        valid_q[slot_idx] <= 1'b1;
        wmark_q[slot_idx] <= ins_write;
        addr_q[slot_idx]  <= ins_addr;
        data_q[slot_idx]  <= ins_data;
        owner_q[slot_idx] <= ins_owner;
      end
      if (free_en) valid_q[free_idx] <= 1'b0;
      count_q <= count_q + CW'(ins_ok) - CW'(free_en);
    end
  end

  ovf_lookup #(.N(N), .AW(AW), .DW(DW)) u_lookup (
    .vis(vis), .wmark(wmark_q), .ent_addr(addr_q), .ent_data(data_q),
    .lk_addr(lk_addr), .hit(lk_hit), .written(lk_written), .data(lk_data)
  );

  ovf_drain #(.N(N), .AW(AW), .DW(DW), .OW(OW)) u_drain (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_commit(cmd_commit), .cmd_owner(cmd_owner),
    .ent_valid(valid_q), .ent_wmark(wmark_q), .ent_owner(owner_q),
    .ent_addr(addr_q), .ent_data(data_q), .mw_ready(mw_ready),
    .busy(busy), .mode(mode), .cur_owner(cur_owner),
    .free_en(free_en), .free_idx(free_idx),
    .mw_valid(mw_valid), .mw_addr(mw_addr), .mw_data(mw_data),
    .rm_valid(rm_valid), .rm_addr(rm_addr)
  );

  assign drain_busy  = busy;
  assign commit_live = busy && (mode == WALK_COMMIT);
  assign ovf_count   = count_q;

  p_count_tracks_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_count == CW'($countones(valid_q))) && (ovf_count <= CW'(N)));

  p_full_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ins_err |=> (ovf_count == $past(ovf_count)) && $stable(valid_q));

  p_insert_counts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ins_ok |=> ovf_count == $past(ovf_count) + CW'(1));

  p_walk_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_busy && ins_valid) |=> $stable(valid_q) || $fell(ovf_count[0]) || $rose(ovf_count[0]));
endmodule

// File: tb/test_ovf_table.sv
`timescale 1ns/1ps
module test_ovf_table;
  localparam int N  = 8;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int OW = 2;
  localparam int CW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          ins_valid = 0, ins_write = 0, cmd_valid = 0, cmd_commit = 0, mw_ready = 1;
  logic [AW-1:0] ins_addr = 0, lk_addr = 0;
  logic [DW-1:0] ins_data = 0;
  logic [OW-1:0] ins_owner = 0, cmd_owner = 0;
  logic          ins_ready, ins_err, lk_hit, lk_written, drain_busy, commit_live, mw_valid, rm_valid;
  logic [DW-1:0] lk_data, mw_data;
  logic [AW-1:0] mw_addr, rm_addr;
  logic [CW-1:0] ovf_count;

  ovf_table #(.N(N), .AW(AW), .DW(DW), .OW(OW)) i_ovf_table (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_addr(ins_addr), .ins_data(ins_data), .ins_write(ins_write), .ins_owner(ins_owner),
    .ins_err(ins_err), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_written(lk_written),
    .lk_data(lk_data), .cmd_valid(cmd_valid), .cmd_commit(cmd_commit), .cmd_owner(cmd_owner),
    .drain_busy(drain_busy), .commit_live(commit_live), .mw_valid(mw_valid),
    .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data), .rm_valid(rm_valid),
    .rm_addr(rm_addr), .ovf_count(ovf_count)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit bp_on = 0, lk_force = 0, saw_b0 = 0;
  int b0_pos = -1, mw_seq = 0;

  // behavioural reference state
  bit            m_v [N];
  bit            m_w [N];
  logic [AW-1:0] m_a [N];
  logic [DW-1:0] m_d [N];
  int            m_o [N];
  bit            m_busy = 0, m_commit = 0, m_rm = 0;
  int            m_cur = 0;
  logic [AW-1:0] m_rm_addr = 0;
  logic [AW-1:0] lk_list [6] = '{16'h0100, 16'h0104, 16'h0108, 16'h010C, 16'h0110, 16'h00B0};

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic step();
    int f, j, cnt, lw;
    bit hit, exp_mw, freed_any;
    int freed;
    mw_ready = bp_on ? ((cyc % 3) != 0) : 1'b1;
    if (!lk_force) lk_addr = lk_list[cyc % 6];
    #1;
    f = -1; for (int i = N - 1; i >= 0; i--) if (!m_v[i]) f = i;
    j = -1; for (int i = N - 1; i >= 0; i--) if (m_v[i] && m_o[i] == m_cur) j = i;
    cnt = 0; for (int i = 0; i < N; i++) if (m_v[i]) cnt++;
    hit = 0; lw = -1;
    for (int i = N - 1; i >= 0; i--) begin
      bit visb;
      visb = m_v[i] && !(m_busy && !m_commit && m_o[i] == m_cur);
      if (visb && m_a[i] == lk_addr) begin
        hit = 1;
        if (m_w[i]) lw = i;
      end
    end
    exp_mw = m_busy && j >= 0 && m_commit && m_w[j];
    chk("R10 ins_ready", ins_ready, !m_busy);
    chk("R3 ins_err", ins_err, ins_valid && !m_busy && f < 0);
    chk("R13 ovf_count", ovf_count, cnt);
    chk("R4 lk_hit", lk_hit, hit);
    chk("R4 lk_written", lk_written, lw >= 0);
    chk("R7 lk_data", lk_data, (lw >= 0) ? m_d[lw] : 0);
    chk("R5 mw_valid", mw_valid, exp_mw);
    if (exp_mw) begin
      chk("R6 mw_addr", mw_addr, m_a[j]);
      chk("R6 mw_data", mw_data, m_d[j]);
    end
    chk("R9 rm_valid", rm_valid, m_rm);
    if (m_rm) chk("R9 rm_addr", rm_addr, m_rm_addr);
    chk("R12 drain_busy", drain_busy, m_busy);
    chk("R8 commit_live", commit_live, m_busy && m_commit);
    // next state of the reference
    freed = -1;
    if (m_busy && j >= 0) begin
      if (exp_mw) begin
        if (mw_ready) begin
          freed = j; mw_seq++;
          if (m_a[j] == 16'h00B0) begin saw_b0 = 1; b0_pos = mw_seq; end
        end
      end else freed = j;
    end
    freed_any = freed >= 0;
    m_rm = freed_any;
    if (freed_any) begin m_rm_addr = m_a[freed]; m_v[freed] = 0; end
    if (ins_valid && !m_busy && f >= 0) begin
      m_v[f] = 1; m_w[f] = ins_write; m_a[f] = ins_addr; m_d[f] = ins_data; m_o[f] = int'(ins_owner);
    end
    if (!m_busy) begin
      if (cmd_valid) begin m_busy = 1; m_commit = cmd_commit; m_cur = int'(cmd_owner); end
    end else if (j < 0) m_busy = 0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(logic [AW-1:0] a, logic [DW-1:0] d, bit w, int o);
    ins_valid = 1; ins_addr = a; ins_data = d; ins_write = w; ins_owner = OW'(o);
    step();
    ins_valid = 0;
  endtask

  task automatic cmd(bit commit, int o);
    cmd_valid = 1; cmd_commit = commit; cmd_owner = OW'(o);
    step();
    cmd_valid = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 60 && m_busy; k++) step();
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_w[i] = 0; m_a[i] = 0; m_d[i] = 0; m_o[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 count after reset", ovf_count, 0);
    chk("R1 busy after reset", drain_busy, 0);
    chk("R1 ready after reset", ins_ready, 1);
    chk("R1 no memory write", mw_valid, 0);
    chk("R1 no removal", rm_valid, 0);
    @(negedge clk);

    put(16'h0100, 32'hA0000001, 1, 0);
    put(16'h0104, 32'hB0000002, 0, 1);
    put(16'h0104, 32'hC0000003, 0, 2);
    put(16'h0108, 32'hD0000004, 1, 1);
    put(16'h010C, 32'hE0000005, 1, 2);
    put(16'h0110, 32'hF0000006, 1, 1);
    lk_force = 1; lk_addr = 16'h0108; #1;
    chk("R2 stored data returned", lk_data, 32'hD0000004);
    chk("R2 count after six inserts", ovf_count, 6);
    lk_force = 0;
    put(16'h0200, 32'h11111111, 1, 3);
    put(16'h0204, 32'h22222222, 0, 3);
    put(16'h0300, 32'h33333333, 1, 0);
    chk("R3 count stays full", ovf_count, N);

    bp_on = 1;
    cmd(1, 1);
    cmd(0, 2);
    put(16'h0400, 32'h44444444, 1, 2);
    wait_idle();
    bp_on = 0;
    chk("R5 owner one drained", ovf_count, 5);

    cmd(0, 2);
    wait_idle();
    chk("R8 owner two removed", ovf_count, 3);
    lk_force = 1; lk_addr = 16'h010C; #1;
    chk("R8 aborted data gone", lk_hit, 0);
    lk_force = 0;

    cmd(1, 1);
    wait_idle();

    mw_seq = 0;
    ins_valid = 1; ins_addr = 16'h00B0; ins_data = 32'h0B0B0B0B; ins_write = 1; ins_owner = 2'd3;
    cmd_valid = 1; cmd_commit = 1; cmd_owner = 2'd3;
    step();
    ins_valid = 0; cmd_valid = 0;
    bp_on = 1;
    wait_idle();
    bp_on = 0;
    chk("R11 same-cycle insert drained", saw_b0, 1);
    chk("R11 drained first from lowest slot", b0_pos, 1);

    cmd(1, 0);
    wait_idle();
    step();
    chk("R13 table empty at end", ovf_count, 0);
    summary();
  end
endmodule